// File: doc/BRIEF.md
# Masked Vector Scatter Line Step

This block carries out a single step of a masked scatter of sixteen 32-bit lanes into memory. A step begins on a start pulse. It takes a source vector, a base address, one signed 32-bit index per lane, a scale code and a lane mask. The block forms every lane's destination address and finds the lowest lane whose mask bit is set. It then selects the 64-byte line that holds that lane's destination.

Every active lane whose destination lies in the selected line is merged into one line write. The write carries a line-aligned address, 512 data bits and a 64-bit byte-enable vector, and it is offered over a valid/ready handshake. Once the write is accepted, the block pulses done and presents the mask with the stored lanes cleared. The caller issues steps again with the returned mask until that mask is zero.

Top module: `scatter_line_step`

## Requirements
- R1: A lane whose mask bit is clear contributes no byte enables and no data to the line write.
- R2: The write address is the destination of the lowest-numbered active lane with its low six bits forced to zero.
- R3: Every active lane whose destination has the same address bits [31:6] as the selected line is stored in that same write. Its four enables cover bytes 4*s to 4*s+3, where s is destination bits [5:2]. Destination bits [1:0] are ignored. Bytes not covered read as zero data with enable low.
- R4: When done pulses, mask_o equals the step's input mask with the bits of exactly the stored lanes cleared.
- R5: A lane's destination is base_i plus the sign-extended index times the scale: code 0 means 1, code 1 means 2, code 2 means 4, code 3 means 8. The sum is taken modulo 2^32.
- R6: When two or more stored lanes share one 4-byte slot, the highest-numbered lane's data is written, and all of their mask bits are cleared.
- R7: wr_valid_o rises on the clock edge that captures start_i. The address, data and enables stay unchanged while ready is low. On the edge where valid and ready are both high, valid falls and done_o pulses high for one cycle.
- R8: A start with an all-zero mask issues no write, and done_o pulses on the next edge with mask_o zero.
- R9: A start_i pulse while a write is still pending is ignored: the pending payload is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one step, sampled at the clock edge |
| base_i | input | 32 | Base byte address |
| idx_i | input | 512 | Sixteen signed 32-bit indices, lane l at bits [32l+31:32l] |
| scale_i | input | 2 | Scale code (0:x1, 1:x2, 2:x4, 3:x8) |
| mask_i | input | 16 | Active lane mask, bit l for lane l |
| data_i | input | 512 | Sixteen 32-bit source elements, lane l at bits [32l+31:32l] |
| wr_valid_o | output | 1 | Line write request valid |
| wr_ready_i | input | 1 | Line write accepted when high with valid |
| wr_addr_o | output | 32 | 64-byte-aligned line address |
| wr_data_o | output | 512 | Line data, byte b at bits [8b+7:8b] |
| wr_be_o | output | 64 | Byte enables, bit b for byte b |
| done_o | output | 1 | One-cycle pulse at the end of a step |
| mask_o | output | 16 | Remaining mask after the step |

## Verification
The line write payload becomes visible in the cycle after the edge that samples start. The bench drives start for one cycle from a falling edge and checks the address, enables and data at the next falling edge. It then holds ready low for a varying number of cycles and confirms at each falling edge that the payload does not change. It raises ready for one cycle, and at the following falling edge it expects done high, valid low and the reduced mask. For a zero mask, done is due at the first falling edge after start.

// File: rtl/scat_pkg.sv
package scat_pkg;

  typedef enum logic [1:0] {
    SC_X1 = 2'd0,
    SC_X2 = 2'd1,
    SC_X4 = 2'd2,
    SC_X8 = 2'd3
  } scale_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } step_state_e;

endpackage

// File: rtl/scat_addr_gen.sv
module scat_addr_gen
  import scat_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned AW    = 32,
  parameter int unsigned IW    = 32
) (
  input  logic [AW-1:0]       base_i,
  input  logic [LANES*IW-1:0] idx_i,
  input  scale_e              scale_i,
  output logic [LANES*AW-1:0] addr_o
);

  logic [1:0] shamt;
  assign shamt = scale_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [IW-1:0] idx_s;
    logic        [AW-1:0] idx_ext;
    assign idx_s   = idx_i[l*IW +: IW];
    assign idx_ext = AW'(idx_s);
    assign addr_o[l*AW +: AW] = base_i + (idx_ext << shamt);
  end

endmodule

// File: rtl/scat_lane_select.sv
module scat_lane_select #(
  parameter int unsigned LANES = 16,
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 6
) (
  input  logic [LANES*AW-1:0] addr_i,
  input  logic [LANES-1:0]    mask_i,
  output logic [AW-1:0]       line_o,
  output logic [LANES-1:0]    hit_o
);

  logic [LANES-1:0] lowest;
  logic [AW-1:0]    lead_addr;

  assign lowest = mask_i & (~mask_i + 1'b1);

  always_comb begin
    lead_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lowest[l]) lead_addr = lead_addr | addr_i[l*AW +: AW];
    end
  end

  assign line_o = {lead_addr[AW-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar l = 0; l < LANES; l++) begin : g_hit
    assign hit_o[l] = mask_i[l] &&
                      (addr_i[l*AW+OFF_W +: AW-OFF_W] == line_o[AW-1:OFF_W]);
  end

  always_comb begin
    assert_lead_onehot_R2: assert ($onehot0(lowest));
    assert_lead_hits_R3: assert ((hit_o & lowest) == lowest);
    assert_hits_active_R1: assert ((hit_o & ~mask_i) == '0);
  end

endmodule

// File: rtl/scat_line_merge.sv
module scat_line_merge #(
  parameter int unsigned LANES      = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned EW         = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic [LANES*AW-1:0]     addr_i,
  input  logic [LANES*EW-1:0]     data_i,
  input  logic [LANES-1:0]        hit_i,
  output logic [LINE_BYTES*8-1:0] data_o,
  output logic [LINE_BYTES-1:0]   be_o
);

  localparam int unsigned EB     = EW / 8;
  localparam int unsigned EB_W   = $clog2(EB);
  localparam int unsigned SLOTS  = LINE_BYTES / EB;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [EW-1:0] word;
    logic          used;
    always_comb begin
      word = '0;
      used = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (hit_i[l] && (addr_i[l*AW+EB_W +: SLOT_W] == SLOT_W'(s))) begin
          word = data_i[l*EW +: EW];
          used = 1'b1;
        end
      end
    end
    assign data_o[s*EW +: EW] = word;
    assign be_o[s*EB +: EB]   = {EB{used}};
  end

endmodule

// File: rtl/scatter_line_step.sv
module scatter_line_step
  import scat_pkg::*;
#(
  parameter int unsigned LANES      = 16,
  parameter int unsigned EW         = 32,
  parameter int unsigned IW         = 32,
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [AW-1:0]           base_i,
  input  logic [LANES*IW-1:0]     idx_i,
  input  logic [1:0]              scale_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*EW-1:0]     data_i,
  output logic                    wr_valid_o,
  input  logic                    wr_ready_i,
  output logic [AW-1:0]           wr_addr_o,
  output logic [LINE_BYTES*8-1:0] wr_data_o,
  output logic [LINE_BYTES-1:0]   wr_be_o,
  output logic                    done_o,
  output logic [LANES-1:0]        mask_o
);

  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned LBITS  = LINE_BYTES * 8;
  localparam int unsigned EB     = EW / 8;
  localparam int unsigned SLOTS  = LINE_BYTES / EB;

  logic [LANES*AW-1:0] lane_addr;
  logic [AW-1:0]       line_addr;
  logic [LANES-1:0]    hit;
  logic [LBITS-1:0]    line_data;
  logic [LINE_BYTES-1:0] line_be;
  scale_e              scale_sel;

  step_state_e         state;
  logic [LANES-1:0]    rest_mask_q;
  logic [LANES-1:0]    start_mask_q;

  assign scale_sel = scale_e'(scale_i);

  scat_addr_gen #(.LANES(LANES), .AW(AW), .IW(IW)) u_addr (
    .base_i (base_i),
    .idx_i  (idx_i),
    .scale_i(scale_sel),
    .addr_o (lane_addr)
  );

  scat_lane_select #(.LANES(LANES), .AW(AW), .OFF_W(OFF_W)) u_sel (
    .addr_i(lane_addr),
    .mask_i(mask_i),
    .line_o(line_addr),
    .hit_o (hit)
  );

  scat_line_merge #(.LANES(LANES), .AW(AW), .EW(EW), .LINE_BYTES(LINE_BYTES)) u_merge (
    .addr_i(lane_addr),
    .data_i(data_i),
    .hit_i (hit),
    .data_o(line_data),
    .be_o  (line_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      wr_valid_o   <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      wr_be_o      <= '0;
      done_o       <= 1'b0;
      mask_o       <= '0;
      rest_mask_q  <= '0;
      start_mask_q <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            start_mask_q <= mask_i;
            if (mask_i == '0) begin
              done_o <= 1'b1;
              mask_o <= '0;
            end else begin
              state       <= ST_SEND;
              wr_valid_o  <= 1'b1;
              wr_addr_o   <= line_addr;
              wr_data_o   <= line_data;
              wr_be_o     <= line_be;
              rest_mask_q <= mask_i & ~hit;
            end
          end
        end
        ST_SEND: begin
          if (wr_ready_i) begin
            state      <= ST_IDLE;
            wr_valid_o <= 1'b0;
            done_o     <= 1'b1;
            mask_o     <= rest_mask_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_line_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (wr_addr_o[OFF_W-1:0] == '0));

  assert_hold_payload_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_be_o) && $stable(wr_data_o)));

  assert_done_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && wr_ready_i) |=> (done_o && !wr_valid_o));

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i && start_i) |=> $stable(start_mask_q));

  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid_o && start_i && (mask_i == '0)) |=>
      (done_o && !wr_valid_o && (mask_o == '0)));

  assert_mask_subset_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((mask_o & ~start_mask_q) == '0));

  assert_progress_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && (start_mask_q != '0)) |-> (mask_o != start_mask_q));

  for (genvar s = 0; s < SLOTS; s++) begin : g_be_chk
    assert_slot_whole_R3: assert property (@(posedge clk) disable iff (rst)
      wr_valid_o |-> ((wr_be_o[s*EB +: EB] == '0) || (wr_be_o[s*EB +: EB] == '1)));
  end

endmodule

// File: tb/test_scatter_line_step.sv
module test_scatter_line_step;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [31:0]  base_i;
  logic [511:0] idx_i;
  logic [1:0]   scale_i;
  logic [15:0]  mask_i;
  logic [511:0] data_i;
  logic         wr_valid_o;
  logic         wr_ready_i;
  logic [31:0]  wr_addr_o;
  logic [511:0] wr_data_o;
  logic [63:0]  wr_be_o;
  logic         done_o;
  logic [15:0]  mask_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [31:0] t_base;
  logic [31:0] t_idx [16];
  logic [31:0] t_dat [16];
  logic [1:0]  t_sc;
  logic [15:0] t_m;

  always #5ns clk = ~clk;

  scatter_line_step i_scatter_line_step (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .idx_i(idx_i),
    .scale_i(scale_i), .mask_i(mask_i), .data_i(data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .done_o(done_o), .mask_o(mask_o)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 16);
  endfunction

  task automatic drive_vec();
    base_i  = t_base;
    scale_i = t_sc;
    mask_i  = t_m;
    for (int l = 0; l < 16; l++) begin
      idx_i[l*32 +: 32]  = t_idx[l];
      data_i[l*32 +: 32] = t_dat[l];
    end
  endtask

  // one step: start, check payload, stall, accept, check mask
  task automatic run_step(input int stall, input string tag);
    logic [31:0]  ea [16];
    logic [31:0]  line;
    logic [15:0]  hitm;
    logic [511:0] exp_d;
    logic [63:0]  exp_be;
    int           lead;
    lead   = -1;
    exp_d  = '0;
    exp_be = '0;
    hitm   = '0;
    for (int l = 0; l < 16; l++) begin
      ea[l] = t_base + t_idx[l] * (32'd1 << t_sc);   // R5
      if (t_m[l] && lead < 0) lead = l;
    end
    line = (lead >= 0) ? (ea[lead] & ~32'h3F) : 32'h0;
    for (int l = 0; l < 16; l++) begin
      if (t_m[l] && (ea[l][31:6] == line[31:6])) begin
        int s;
        hitm[l] = 1'b1;
        s = int'(ea[l][5:2]);
        exp_d[s*32 +: 32] = t_dat[l];      // later lane overrides: R6
        exp_be[s*4 +: 4]  = 4'hF;
      end
    end
    @(negedge clk);
    drive_vec();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (t_m == 16'h0) begin
      chk({tag, " R8 done"}, 512'(done_o), 512'(1'b1));
      chk({tag, " R8 no write"}, 512'(wr_valid_o), 512'(1'b0));
      chk({tag, " R8 mask"}, 512'(mask_o), 512'(16'h0));
      return;
    end
    chk({tag, " R7 valid"}, 512'(wr_valid_o), 512'(1'b1));
    chk({tag, " R2 addr"}, 512'(wr_addr_o), 512'(line));
    chk({tag, " R1 R3 be"}, 512'(wr_be_o), 512'(exp_be));
    chk({tag, " R3 R6 data"}, wr_data_o, exp_d);
    for (int k = 0; k < stall; k++) begin
      // second start while pending must be ignored (R9)
      base_i  = base_i + 32'h400;
      mask_i  = ~mask_i;
      start_i = (k == 0);
      @(negedge clk);
      start_i = 1'b0;
      chk({tag, " R7 R9 hold valid"}, 512'(wr_valid_o), 512'(1'b1));
      chk({tag, " R7 R9 hold addr"}, 512'(wr_addr_o), 512'(line));
      chk({tag, " R7 R9 hold be"}, 512'(wr_be_o), 512'(exp_be));
      chk({tag, " R7 R9 hold data"}, wr_data_o, exp_d);
    end
    wr_ready_i = 1'b1;
    @(negedge clk);
    wr_ready_i = 1'b0;
    chk({tag, " R7 done"}, 512'(done_o), 512'(1'b1));
    chk({tag, " R7 valid low"}, 512'(wr_valid_o), 512'(1'b0));
    chk({tag, " R4 R6 mask"}, 512'(mask_o), 512'(t_m & ~hitm));
    @(negedge clk);
    chk({tag, " R7 done pulse"}, 512'(done_o), 512'(1'b0));
    t_m = t_m & ~hitm;
  endtask

  task automatic run_scatter(input string tag);
    int steps;
    steps = 0;
    while (t_m != 16'h0 && steps < 17) begin
      run_step(steps % 3, tag);
      steps++;
    end
    chk({tag, " R4 completes"}, 512'(t_m), 512'(16'h0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; wr_ready_i = 1'b0;
    base_i = '0; idx_i = '0; scale_i = '0; mask_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset R7 valid", 512'(wr_valid_o), 512'(1'b0));
    chk("reset R7 done", 512'(done_o), 512'(1'b0));
    chk("reset R4 mask", 512'(mask_o), 512'(16'h0));

    // zero mask: R8
    t_base = 32'h100; t_sc = 2'd2; t_m = 16'h0;
    for (int l = 0; l < 16; l++) begin t_idx[l] = l; t_dat[l] = 32'hA000 + l; end
    run_step(0, "zero");

    // all lanes contiguous in one line: R3
    t_base = 32'h2000; t_sc = 2'd2; t_m = 16'hFFFF;
    for (int l = 0; l < 16; l++) begin t_idx[l] = 15 - l; t_dat[l] = 32'hB000 + l; end
    run_step(1, "oneline");
    chk("oneline R3 single step", 512'(t_m), 512'(16'h0));

    // duplicate slot: lanes 3 and 9 collide, lane 9 wins: R6
    t_base = 32'h3000; t_sc = 2'd3; t_m = 16'h0208;
    for (int l = 0; l < 16; l++) begin t_idx[l] = 32'd40 + l; t_dat[l] = 32'hC000 + l; end
    t_idx[3] = 32'd2; t_idx[9] = 32'd2;
    run_step(0, "dup");
    chk("dup R6 cleared both", 512'(t_m), 512'(16'h0));

    // negative index with scale 8, inactive lanes pointing into the same line: R5 R1
    t_base = 32'h0001_0000; t_sc = 2'd3; t_m = 16'h0010;
    for (int l = 0; l < 16; l++) begin t_idx[l] = -32'sd3; t_dat[l] = 32'hD000 + l; end
    t_idx[4] = -32'sd3;
    run_step(0, "neg");

    // sweep: every scale code, varied masks, clustered indices
    for (int n = 0; n < 160; n++) begin
      t_base = (rnd() & 32'h0000_FFC0) | ((n % 4 == 0) ? 32'h0 : (rnd() & 32'h3C));
      t_sc   = 2'(n % 4);
      t_m    = (n % 16 == 5) ? 16'hFFFF : 16'(rnd());
      for (int l = 0; l < 16; l++) begin
        t_idx[l] = (rnd() % 48) - 32'd8;
        t_dat[l] = rnd();
      end
      run_scatter($sformatf("sweep%0d", n));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule